// File: doc/BRIEF.md
# Interrupt pending and mask controller

This block keeps the per-source request state for a bank of interrupt sources and presents two request lines to a processor. A normal request line is served through a post-arbitration stage, and a fast request line bypasses it. Every incoming request is recorded in a raw pending register, even when the source is disabled. A separate priority tree, outside this block, proposes a winner index with a valid flag. The block latches that winner as a single set bit in an arbitrated pending register, provided the winner is pending, enabled and configured for the normal line.

Software uses a small register bus. It can read and write the raw pending, mask, mode and arbitrated pending registers, and it can read an offset register that gives the index of the arbitrated bit. Both pending registers are cleared by writing ones. The expected service order is to clear the raw pending bit first and the arbitrated bit second. After that, the next winner can be latched.

Top module: `intc_pend_mask`

## Requirements
- R1: A high `src_req[i]` on a clock edge sets raw pending bit i at that edge, whatever the mask bit i holds.
- R2: A bus write to address 0 clears every raw pending bit whose write-data bit is 1. Bits written with 0 keep their value. If a request and a clear hit the same bit in the same cycle, the bit stays set.
- R3: When the arbitrated pending register is all zeros and `arb_vld` is high, it loads a one-hot value with bit `arb_idx` set at that edge. This happens only if that source is raw-pending, unmasked (mask bit 0) and in normal mode (mode bit 0).
- R4: A winner whose mask bit is 1 leaves the arbitrated pending register unchanged.
- R5: The arbitrated pending register never holds more than one set bit. While it is nonzero, further winners are ignored.
- R6: A bus write to address 3 clears the arbitrated bits written with 1. Writing 0 has no effect.
- R7: `irq` is high exactly when the arbitrated pending register is nonzero.
- R8: `fiq` is high when any source is raw-pending, unmasked and has mode bit 1. A winner with mode bit 1 never loads the arbitrated pending register.
- R9: A read of address 4 returns the index of the set arbitrated bit, and 0 when none is set.
- R10: The register map is 0 raw pending, 1 mask, 2 mode (1 selects the fast line), 3 arbitrated pending and 4 offset. Reads are combinational. After reset, raw pending is 0, mask is all ones, mode is 0 and arbitrated pending is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NSRC | Per-source request, sampled each edge |
| arb_idx | input | IDXW | Winner index from the priority tree |
| arb_vld | input | 1 | Winner index is valid |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data for `bus_addr` |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Requests, clears and winner loads take effect at the first rising edge after they are driven. The request lines and the read data follow the registers without further delay. The bench therefore drives each stimulus at a falling edge and removes it at the next falling edge. It samples `irq`, `fiq` and read data just after that second falling edge, when exactly one rising edge has acted. Every source index is swept through its masked, unmasked and fast paths, so each result is checked one edge after its cause.

// File: rtl/intc_pend_mask.sv
module intc_pend_mask #(
  parameter int NSRC = 32,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [IDXW-1:0] arb_idx,
  input  logic            arb_vld,
  input  logic            bus_wr,
  input  logic [2:0]      bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq,
  output logic            fiq
);
  localparam logic [2:0] A_SRC = 3'd0, A_MSK = 3'd1, A_MOD = 3'd2, A_ARB = 3'd3, A_OFS = 3'd4;

  logic [NSRC-1:0] srcpend, mask, mode, arbpend;
  logic [IDXW-1:0] offset;

  wire wr_src = bus_wr && bus_addr == A_SRC;
  wire wr_arb = bus_wr && bus_addr == A_ARB;
  wire win_ok = arb_vld && srcpend[arb_idx] && !mask[arb_idx] && !mode[arb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcpend <= '0;
      mask    <= '1;
      mode    <= '0;
      arbpend <= '0;
    end else begin
      srcpend <= (srcpend & ~(wr_src ? bus_wdata : '0)) | src_req;
      if (bus_wr && bus_addr == A_MSK) mask <= bus_wdata;
      if (bus_wr && bus_addr == A_MOD) mode <= bus_wdata;
      if (arbpend == '0) begin
        if (win_ok) arbpend <= NSRC'(1) << arb_idx;
      end else if (wr_arb) begin
        arbpend <= arbpend & ~bus_wdata;
      end
    end
  end

  always_comb begin
    offset = '0;
    for (int i = 0; i < NSRC; i++)
      if (arbpend[i]) offset = IDXW'(i);
  end

  always_comb begin
    case (bus_addr)
      A_SRC:   bus_rdata = srcpend;
      A_MSK:   bus_rdata = mask;
      A_MOD:   bus_rdata = mode;
      A_ARB:   bus_rdata = arbpend;
      A_OFS:   bus_rdata = {{(NSRC-IDXW){1'b0}}, offset};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = |arbpend;
  assign fiq = |(srcpend & ~mask & mode);
endmodule

module intc_pend_mask_chk #(
  parameter int NSRC = 32,
  parameter int IDXW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [IDXW-1:0] arb_idx,
  input logic            arb_vld,
  input logic [NSRC-1:0] srcpend,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] mode,
  input logic [NSRC-1:0] arbpend,
  input logic            irq,
  input logic            bus_wr,
  input logic [2:0]      bus_addr,
  input logic [NSRC-1:0] bus_wdata
);
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(arbpend));

  a_r1_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((srcpend & $past(src_req)) == $past(src_req)));

  a_r4_masked_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_vld && mask[arb_idx] && arbpend == '0) |=> (arbpend == '0));

  a_r8_fast_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_vld && mode[arb_idx] && arbpend == '0) |=> (arbpend == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (arbpend != '0 && !(bus_wr && bus_addr == 3'd3 && (bus_wdata & arbpend) != '0)) |=> $stable(arbpend));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(arb_vld));
endmodule

bind intc_pend_mask intc_pend_mask_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .arb_idx(arb_idx), .arb_vld(arb_vld),
  .srcpend(srcpend), .mask(mask), .mode(mode), .arbpend(arbpend), .irq(irq),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/test_intc_pend_mask.sv
module test_intc_pend_mask;
  localparam int NSRC = 32;
  localparam int IDXW = 5;

  logic            clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_req = '0, bus_wdata = '0, bus_rdata;
  logic [IDXW-1:0] arb_idx = '0;
  logic            arb_vld = 0, bus_wr = 0, irq, fiq;
  logic [2:0]      bus_addr = '0;
  int checks = 0, errors = 0;

  intc_pend_mask #(.NSRC(NSRC), .IDXW(IDXW)) i_intc_pend_mask (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .arb_idx(arb_idx), .arb_vld(arb_vld),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .fiq(fiq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [NSRC-1:0] got, input logic [NSRC-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [NSRC-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [NSRC-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] r);
    @(negedge clk); src_req = r;
    @(negedge clk); src_req = '0;
  endtask

  task automatic win(input int idx);
    @(negedge clk); arb_idx = IDXW'(idx); arb_vld = 1;
    @(negedge clk); arb_vld = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NSRC-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rreg(0, d); chk("R10 srcpend reset", d, '0);
    rreg(1, d); chk("R10 mask reset", d, '1);
    rreg(2, d); chk("R10 mode reset", d, '0);
    rreg(3, d); chk("R10 arbpend reset", d, '0);
    rreg(4, d); chk("R9 offset reset", d, '0);
    chk("R7 irq reset", {31'd0, irq}, '0);
    chk("R8 fiq reset", {31'd0, fiq}, '0);

    for (int i = 0; i < NSRC; i++) begin
      logic [NSRC-1:0] b;
      b = NSRC'(1) << i;
      // masked path
      wreg(1, '1);
      pulse(b);
      rreg(0, d); chk("R1 masked request recorded", d, b);
      win(i);
      rreg(3, d); chk("R4 masked winner ignored", d, '0);
      chk("R7 irq low when masked", {31'd0, irq}, '0);
      wreg(0, '0);
      rreg(0, d); chk("R2 write zero keeps srcpend", d, b);
      wreg(0, b);
      rreg(0, d); chk("R2 write one clears srcpend", d, '0);
      // normal path
      wreg(1, ~b);
      pulse(b);
      win(i);
      rreg(3, d); chk("R3 winner latched one-hot", d, b);
      chk("R7 irq high", {31'd0, irq}, 32'd1);
      rreg(4, d); chk("R9 offset index", d, NSRC'(i));
      pulse(NSRC'(1) << ((i + 1) % NSRC));
      wreg(1, '0);
      win((i + 1) % NSRC);
      rreg(3, d); chk("R5 second winner ignored", d, b);
      wreg(3, '0);
      rreg(3, d); chk("R6 write zero keeps arbpend", d, b);
      wreg(0, '1);
      wreg(3, b);
      rreg(3, d); chk("R6 write one clears arbpend", d, '0);
      chk("R7 irq low after clear", {31'd0, irq}, '0);
      // fast path
      wreg(1, ~b);
      wreg(2, b);
      pulse(b);
      chk("R8 fiq high", {31'd0, fiq}, 32'd1);
      win(i);
      rreg(3, d); chk("R8 fast winner not latched", d, '0);
      wreg(0, b);
      chk("R8 fiq low after clear", {31'd0, fiq}, '0);
      wreg(2, '0);
    end

    // request and clear on the same bit in the same cycle
    @(negedge clk);
    src_req = NSRC'(1) << 5; bus_addr = 0; bus_wdata = NSRC'(1) << 5; bus_wr = 1;
    @(negedge clk);
    src_req = '0; bus_wr = 0;
    rreg(0, d); chk("R2 request beats clear", d, NSRC'(1) << 5);
    wreg(0, '1);
    rreg(0, d); chk("R2 cleared afterwards", d, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule